// File: doc/BRIEF.md
# Configurable-Width Dual-Clock Block RAM

This block is a 4096-bit simple dual-port memory with one write port and one read port, each on its own clock. Each port picks its word width on its own through a 2-bit mode input: 16, 8, 4 or 2 bits. In the narrow widths the word does not sit on the low bits of the 16-bit buses. It sits on a fixed set of spread-out lanes instead. Integrators wire narrow data to those lanes and leave the other bus bits unused.

Storage is organised as 256 physical rows of 16 bits. A narrow word at address A occupies one slice of row A / (16 / width). Both ports use the same slicing, so a word written at one width can be read back at any other width. Viewed linearly, data bit k of the word at address A in width w is memory bit A*w + k. A parameter selects the active level of the power-up enable input. Two further parameters invert the write clock and the read clock independently, so each port can act on either edge.

Top module: `cfg_width_bram`

## Requirements
- R1: Mode encoding on both ports is 0 = 16 bits (256 words), 1 = 8 bits (512), 2 = 4 bits (1024) and 3 = 2 bits (2048). Only the low 8, 9, 10 or 11 address bits are used, and higher address bits are ignored.
- R2: In 8-bit mode, data bits 7 down to 0 travel on bus bits 14, 12, 10, 8, 6, 4, 2 and 0 respectively. This holds on both the write data bus and the read data bus.
- R3: In 4-bit mode, data bits 3 down to 0 travel on bus bits 13, 9, 5 and 1. In 2-bit mode, data bits 1 and 0 travel on bus bits 11 and 3.
- R4: In narrow modes, write-bus bits outside the active lanes have no effect on the stored data, and read-bus bits outside the active lanes read as 0.
- R5: In 16-bit mode, a mask bit at 1 blocks the write of that data bit. In narrow modes the mask is ignored.
- R6: A write happens only on the active write-clock edge, and only when the write clock enable and the write enable are both 1.
- R7: The read data register loads only on the active read-clock edge, and only when the read clock enable and the read enable are both 1. Otherwise it holds its value.
- R8: Data bit k of the word at address A in width w is memory bit A*w+k. Data written at one width therefore reads back at any other width.
- R9: When the read-clock inversion parameter is set, the read data register loads on the falling edge of the read clock. The write port behaves the same way under its own inversion parameter.
- R10: While the power-up enable is not at its active level, writes are ignored and the read data output is 0. The register is cleared on each active read edge during that time, so the output stays 0 after power returns until the next read.
- R11: While rst_n is 0 at an active read edge, the read data register clears to 0, and writes are ignored during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wclke | input | 1 | Write clock enable |
| we | input | 1 | Write enable |
| wmode | input | 2 | Write width mode |
| waddr | input | 11 | Write word address |
| wdata | input | 16 | Write data bus (lane-mapped in narrow modes) |
| wmask | input | 16 | Per-bit write block, 16-bit mode only |
| rclk | input | 1 | Read clock |
| rclke | input | 1 | Read clock enable |
| re | input | 1 | Read enable |
| rmode | input | 2 | Read width mode |
| raddr | input | 11 | Read word address |
| rdata | output | 16 | Registered read data bus |
| rst_n | input | 1 | Synchronous active-low reset, sampled on each port's clock |
| pwr_en | input | 1 | Memory power-up enable, active level set by parameter |

## Verification
If the row or slice decode is wrong, the data shows up at the wrong address or width. This is seen on the first read of that location, one active read edge after the read is issued. Because the reference keeps a linear bit image, reads at a different width expose a slicing error at once. A lane or mask error changes which bus bits carry data. The same read shows it as nonzero unused lanes or as a blocked or unblocked bit. A wrong enable or power gate shows up on the next read edge, either as a register that moves when it should hold or as a nonzero output while powered down.

// File: rtl/bram_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, the width-mode type and lane-mapping helpers.
// Assumes a 16-bit physical row; the narrow lane layout is defined for that row.
package bram_pkg;
    localparam int ROW_W  = 16;
    localparam int MODE_W = 2;
    localparam int RIDX_W = $clog2(ROW_W);

    typedef logic [MODE_W-1:0] mode_t;

    // Bus bit that carries data bit k in the given width mode.
    function automatic int unsigned lane_of(mode_t m, int unsigned k);
        int unsigned base;
        base = (m == 2'd0) ? 0 : ((32'd1 << (int'(m) - 1)) - 1);
        return (k << m) + base;
    endfunction

    // Set of bus bits active in the given width mode.
    function automatic logic [ROW_W-1:0] lane_mask(mode_t m);
        logic [ROW_W-1:0] v;
        v = '0;
        for (int k = 0; k < ROW_W; k++) begin
            if (k < (ROW_W >> m)) v[RIDX_W'(lane_of(m, 32'(k)))] = 1'b1;
        end
        return v;
    endfunction
endpackage

// File: rtl/bram_wr_map.sv
`timescale 1ns/1ps
// Module: write mapper. Turns a word address, lane-mapped data and mask into
// a physical row index, a per-bit enable vector and row-aligned data.
// Assumes ROW_W = 16; the mask applies only in full-width mode.
module bram_wr_map
    import bram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int ROW_AW = 8
) (
    input  mode_t             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ROW_W-1:0]  data,
    input  logic [ROW_W-1:0]  mask,
    output logic [ROW_AW-1:0] row,
    output logic [ROW_W-1:0]  be,
    output logic [ROW_W-1:0]  d
);
    // Decode row and slot, then gather lane bits into the slot's row positions.
    always_comb begin
        int unsigned wid;
        int unsigned slot;
        logic [RIDX_W-1:0] pos;
        wid  = 32'(ROW_W) >> mode;
        slot = 32'(addr) & ((32'd1 << mode) - 1);
        row  = ROW_AW'(addr >> mode);
        be   = '0;
        d    = '0;
        pos  = '0;
        for (int k = 0; k < ROW_W; k++) begin
            if (32'(k) < wid) begin
                pos     = RIDX_W'(slot * wid + 32'(k));
                d[pos]  = data[RIDX_W'(lane_of(mode, 32'(k)))];
                be[pos] = (mode == 2'd0) ? ~mask[k] : 1'b1;
            end
        end
    end
endmodule

// File: rtl/bram_rd_map.sv
`timescale 1ns/1ps
// Module: read mapper. Selects the slot of a physical row addressed by a word
// address and spreads it onto the lane-mapped read bus; other lanes are 0.
// Assumes ROW_W = 16.
module bram_rd_map
    import bram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int ROW_AW = 8
) (
    input  mode_t             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ROW_W-1:0]  row_q,
    output logic [ROW_AW-1:0] row,
    output logic [ROW_W-1:0]  bus
);
    // Decode row and slot, then scatter the slot's bits onto their lanes.
    always_comb begin
        int unsigned wid;
        int unsigned slot;
        logic [RIDX_W-1:0] pos;
        wid  = 32'(ROW_W) >> mode;
        slot = 32'(addr) & ((32'd1 << mode) - 1);
        row  = ROW_AW'(addr >> mode);
        bus  = '0;
        pos  = '0;
        for (int k = 0; k < ROW_W; k++) begin
            if (32'(k) < wid) begin
                pos = RIDX_W'(slot * wid + 32'(k));
                bus[RIDX_W'(lane_of(mode, 32'(k)))] = row_q[pos];
            end
        end
    end
endmodule

// File: rtl/bram_store.sv
`timescale 1ns/1ps
// Module: physical storage of ROWS x ROW_W bits with per-bit write enables
// and an asynchronous row read. Contents are not reset.
// Assumes the caller has already qualified the write with every enable.
module bram_store
    import bram_pkg::*;
#(
    parameter int ROWS   = 256,
    parameter int ROW_AW = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              wr_go,
    input  logic [ROW_AW-1:0] w_row,
    input  logic [ROW_W-1:0]  w_be,
    input  logic [ROW_W-1:0]  w_d,
    input  logic [ROW_AW-1:0] r_row,
    output logic [ROW_W-1:0]  r_q
);
    logic [ROW_W-1:0] mem [ROWS];

    // Bit-enabled row write on the effective write clock.
    always_ff @(posedge clk) begin
        if (wr_go) begin
            for (int b = 0; b < ROW_W; b++) begin
                if (w_be[b]) mem[w_row][b] <= w_d[b];
            end
        end
    end

    // Row read path feeding the read mapper.
    assign r_q = mem[r_row];
endmodule

// File: rtl/cfg_width_bram.sv
`timescale 1ns/1ps
// Module: top of the configurable-width dual-clock block RAM. Applies clock
// polarity, the power-up level and write qualification, and holds the read
// data register. Assumes rst_n is held low for at least one edge of each clock.
module cfg_width_bram
    import bram_pkg::*;
#(
    parameter int ADDR_W          = 11,
    parameter int ROWS            = 256,
    parameter bit WCLK_NEG        = 1'b0,
    parameter bit RCLK_NEG        = 1'b0,
    parameter bit PWR_ACTIVE_HIGH = 1'b1
) (
    input  logic              wclk,
    input  logic              wclke,
    input  logic              we,
    input  logic [1:0]        wmode,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [15:0]       wdata,
    input  logic [15:0]       wmask,
    input  logic              rclk,
    input  logic              rclke,
    input  logic              re,
    input  logic [1:0]        rmode,
    input  logic [ADDR_W-1:0] raddr,
    output logic [15:0]       rdata,
    input  logic              rst_n,
    input  logic              pwr_en
);
    localparam int ROW_AW = $clog2(ROWS);

    logic              wclk_e;
    logic              rclk_e;
    logic              pwr_on;
    logic              wr_go;
    logic [ROW_AW-1:0] w_row;
    logic [ROW_W-1:0]  w_be;
    logic [ROW_W-1:0]  w_d;
    logic [ROW_AW-1:0] r_row;
    logic [ROW_W-1:0]  r_q;
    logic [ROW_W-1:0]  r_bus;
    logic [ROW_W-1:0]  rdata_q;

    // Effective clocks after the per-port polarity choice.
    assign wclk_e = WCLK_NEG ? ~wclk : wclk;
    assign rclk_e = RCLK_NEG ? ~rclk : rclk;
    // Power-up enable at its configured active level.
    assign pwr_on = PWR_ACTIVE_HIGH ? pwr_en : ~pwr_en;
    // Fully qualified write strobe.
    assign wr_go  = rst_n & pwr_on & wclke & we;

    bram_wr_map #(.ADDR_W(ADDR_W), .ROW_AW(ROW_AW)) u_wr (
        .mode (wmode),
        .addr (waddr),
        .data (wdata),
        .mask (wmask),
        .row  (w_row),
        .be   (w_be),
        .d    (w_d)
    );

    bram_store #(.ROWS(ROWS), .ROW_AW(ROW_AW)) u_mem (
        .clk   (wclk_e),
        .wr_go (wr_go),
        .w_row (w_row),
        .w_be  (w_be),
        .w_d   (w_d),
        .r_row (r_row),
        .r_q   (r_q)
    );

    bram_rd_map #(.ADDR_W(ADDR_W), .ROW_AW(ROW_AW)) u_rd (
        .mode  (rmode),
        .addr  (raddr),
        .row_q (r_q),
        .row   (r_row),
        .bus   (r_bus)
    );

    // Read data register: reset and power-down clear it, an enabled read loads it.
    always_ff @(posedge rclk_e) begin
        if (!rst_n)             rdata_q <= '0;
        else if (!pwr_on)       rdata_q <= '0;
        else if (rclke && re)   rdata_q <= r_bus;
    end

    // Output forced to zero while powered down.
    assign rdata = pwr_on ? rdata_q : '0;
endmodule

// File: rtl/cfg_width_bram_chk.sv
`timescale 1ns/1ps
// Module: assertion checker bound to cfg_width_bram. Watches the read port
// on the effective read clock and the write enables on the effective write clock.
module cfg_width_bram_chk
    import bram_pkg::*;
#(
    parameter bit WCLK_NEG        = 1'b0,
    parameter bit RCLK_NEG        = 1'b0,
    parameter bit PWR_ACTIVE_HIGH = 1'b1
) (
    input logic        wclk,
    input logic        rclk,
    input logic        rst_n,
    input logic        pwr_en,
    input logic [1:0]  wmode,
    input logic [1:0]  rmode,
    input logic        rclke,
    input logic        re,
    input logic [15:0] wmask,
    input logic [15:0] rdata,
    input logic [15:0] w_be
);
    logic wck;
    logic rck;
    logic pon;
    assign wck = WCLK_NEG ? ~wclk : wclk;
    assign rck = RCLK_NEG ? ~rclk : rclk;
    assign pon = PWR_ACTIVE_HIGH ? pwr_en : ~pwr_en;

    // R4: after a read, only the lanes of that read's mode may be nonzero.
    assert_unused_lanes_zero_R4: assert property (@(posedge rck) disable iff (!rst_n)
        (pon && rclke && re) |=> ((rdata & ~lane_mask($past(rmode))) == 16'h0));

    // R7: with no enabled read, the output holds while powered.
    assert_hold_rdata_R7: assert property (@(posedge rck) disable iff (!rst_n)
        (pon && !(rclke && re)) |=> (!pon || $stable(rdata)));

    // R10: a powered-down edge without a read leaves the output at zero.
    assert_powerdown_zero_R10: assert property (@(posedge rck) disable iff (!rst_n)
        (!pon && !(rclke && re)) |=> (rdata == 16'h0));

    // R5: in full-width mode a masked bit is never write-enabled.
    assert_mask_blocks_R5: assert property (@(posedge wck) disable iff (!rst_n)
        (wmode == 2'd0) |-> ((w_be & wmask) == 16'h0));

    // R3: in narrow modes exactly one word's worth of row bits is enabled.
    assert_narrow_enable_count_R3: assert property (@(posedge wck) disable iff (!rst_n)
        (wmode != 2'd0) |-> ($countones(w_be) == (32'd16 >> wmode)));
endmodule

bind cfg_width_bram cfg_width_bram_chk #(
    .WCLK_NEG        (WCLK_NEG),
    .RCLK_NEG        (RCLK_NEG),
    .PWR_ACTIVE_HIGH (PWR_ACTIVE_HIGH)
) u_chk (
    .wclk   (wclk),
    .rclk   (rclk),
    .rst_n  (rst_n),
    .pwr_en (pwr_en),
    .wmode  (wmode),
    .rmode  (rmode),
    .rclke  (rclke),
    .re     (re),
    .wmask  (wmask),
    .rdata  (rdata),
    .w_be   (w_be)
);

// File: tb/sim_cfg_width_bram.sv
`timescale 1ns/100ps
// Bench: one clock drives both ports; writes act on the rising edge, and reads
// act on the falling edge (read clock inverted). A linear 4096-bit model gives
// the expected read register, compared once per cycle.
module sim_cfg_width_bram;
    logic        clk = 1'b0;
    logic        wclke = 0, we = 0, rclke = 0, re = 0, rst_n = 0, pwr_en = 1;
    logic [1:0]  wmode = 0, rmode = 0;
    logic [10:0] waddr = 0, raddr = 0;
    logic [15:0] wdata = 0, wmask = 0;
    logic [15:0] rdata;

    bit          mdl [0:4095];
    logic [15:0] exp_q = 16'h0;
    int          checks = 0;
    int          errors = 0;
    string       req = "R11";
    bit          done = 0;

    always #2 clk = ~clk;

    cfg_width_bram #(.WCLK_NEG(1'b0), .RCLK_NEG(1'b1), .PWR_ACTIVE_HIGH(1'b1)) u0 (
        .wclk(clk), .wclke(wclke), .we(we), .wmode(wmode), .waddr(waddr),
        .wdata(wdata), .wmask(wmask), .rclk(clk), .rclke(rclke), .re(re),
        .rmode(rmode), .raddr(raddr), .rdata(rdata), .rst_n(rst_n), .pwr_en(pwr_en)
    );

    function automatic int lane(int m, int k);
        case (m)
            0: return k;
            1: return 2 * k;
            2: return 4 * k + 1;
            default: return 8 * k + 3;
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s rdata=%h expected=%h", tag, act, expv);
        end
    endtask

    // Apply this cycle's inputs to the model: read at the falling edge, then write.
    task automatic model_cycle();
        int w;
        int a;
        if (!rst_n || !pwr_en) exp_q = 16'h0;
        else if (rclke && re) begin
            w = 16 >> rmode;
            a = int'(raddr) % (256 << rmode);
            exp_q = 16'h0;
            for (int k = 0; k < w; k++) exp_q[lane(int'(rmode), k)] = mdl[a * w + k];
        end
        if (rst_n && pwr_en && wclke && we) begin
            w = 16 >> wmode;
            a = int'(waddr) % (256 << wmode);
            for (int k = 0; k < w; k++)
                if (wmode != 0 || !wmask[k]) mdl[a * w + k] = wdata[lane(int'(wmode), k)];
        end
    endtask

    // Called one ns after a rising edge, with inputs already set.
    task automatic step();
        model_cycle();
        @(posedge clk);
        #1;
        check(req, rdata, exp_q);
    endtask

    task automatic wr(int m, int a, logic [15:0] d, logic [15:0] mk);
        wmode = 2'(m); waddr = 11'(a); wdata = d; wmask = mk;
        wclke = 1; we = 1; rclke = 0; re = 0;
        step();
        wclke = 0; we = 0;
    endtask

    task automatic rd(int m, int a);
        rmode = 2'(m); raddr = 11'(a); rclke = 1; re = 1;
        step();
        rclke = 0; re = 0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] old;
        @(posedge clk); #1;
        // R11: reset clears the read register
        req = "R11";
        rclke = 1; re = 1;
        for (int i = 0; i < 3; i++) step();
        rclke = 0; re = 0;
        rst_n = 1;
        step();

        // R1: fill all rows at full width, read back with high address bits set
        req = "R1";
        for (int i = 0; i < 256; i++) wr(0, i, 16'(i * 16'h9E37) ^ 16'h5A5A, 16'h0);
        for (int i = 0; i < 256; i += 17) rd(0, i | 11'h700);

        // R11: write during reset is ignored
        req = "R11";
        rst_n = 0;
        wr(0, 5, 16'hFFFF, 16'h0);
        rst_n = 1;
        step();
        rd(0, 5);

        // R2: 8-bit lanes, garbage on unused bits (R4)
        req = "R2";
        wr(1, 7, 16'hAAAA, 16'h0);
        wr(1, 8, 16'h5555, 16'hFFFF);
        wr(1, 9 | 11'h600, 16'h4001, 16'h0);
        rd(1, 7); rd(1, 8); rd(1, 9);
        // R8: read 8-bit data back at full width
        req = "R8";
        rd(0, 4);

        // R3: 4-bit and 2-bit lanes
        req = "R3";
        wr(2, 100, 16'h2222, 16'h0);
        wr(2, 101, 16'hDDDD, 16'h0);
        wr(3, 600, 16'h0808, 16'h0);
        wr(3, 601, 16'hF7F7, 16'h0);
        rd(2, 100); rd(2, 101); rd(3, 600); rd(3, 601);
        // R4: unused lanes read as zero from an all-ones row
        req = "R4";
        wr(0, 200, 16'hFFFF, 16'h0);
        rd(3, 1600); rd(2, 801); rd(1, 401);
        // R8: cross-width readback
        req = "R8";
        rd(0, 25); rd(1, 201); rd(2, 400); rd(3, 4799);

        // R5: mask at full width, ignored at narrow width
        req = "R5";
        wr(0, 30, 16'h0000, 16'h0000);
        wr(0, 30, 16'hFFFF, 16'hF0F0);
        rd(0, 30);
        wr(1, 62, 16'hFFFF, 16'hFFFF);
        rd(0, 31);

        // R6: a write needs both write enables
        req = "R6";
        wmode = 0; waddr = 11'd40; wdata = 16'h1234; wclke = 0; we = 1;
        step();
        wclke = 1; we = 0;
        step();
        wclke = 0;
        rd(0, 40);

        // R7: register holds without both read enables
        req = "R7";
        rmode = 0; raddr = 11'd41; rclke = 0; re = 1;
        step();
        rclke = 1; re = 0;
        step();
        rclke = 0;
        step();

        // R9: read register loads on the falling edge
        req = "R9";
        old = exp_q;
        rmode = 0; raddr = 11'd77; rclke = 1; re = 1;
        model_cycle();
        #0.5;
        check("R9 before falling edge", rdata, old);
        #1;
        check("R9 after falling edge", rdata, exp_q);
        @(posedge clk); #1;
        check("R9", rdata, exp_q);
        rclke = 0; re = 0;

        // R10: powered down, writes ignored, output zero
        req = "R10";
        pwr_en = 0;
        wr(0, 50, 16'hBEEF, 16'h0);
        rd(0, 50);
        pwr_en = 1;
        step();
        rd(0, 50);

        // R8: random mix of widths, addresses and enables
        req = "R8";
        for (int i = 0; i < 1500; i++) begin
            wmode = 2'($urandom); rmode = 2'($urandom);
            waddr = 11'($urandom); raddr = 11'($urandom);
            wdata = 16'($urandom); wmask = 16'($urandom);
            wclke = ($urandom % 4) != 0; we = ($urandom % 4) != 0;
            rclke = ($urandom % 4) != 0; re = ($urandom % 4) != 0;
            pwr_en = ($urandom % 20) != 0;
            step();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule